// File: doc/BRIEF.md
# Charger Watchdog Timeout Controller

This block guards a battery charger against a host that has stopped talking to it. Two timers run against a slow, prescaled tick. The first counts ticks since the last completed write to either the charge-voltage register or the charge-current register. The second counts ticks for which the sampled clock line of the two-wire management bus has stayed low without a break. If either timer runs out while charging is on, the charge-enable output drops and a sticky two-bit cause code records which timer fired.

Only a new completed write to one of those two registers turns charging back on. The register decoder feeds those writes in as one-cycle strobes. Any other bus traffic, such as reads or writes to other registers, never reaches this block and so has no effect. A qualifying write restarts the write timer and clears the cause code.

Both timer lengths are parameters counted in ticks, so a simulation can use short values. The defaults assume a 1 ms tick.

Top module: `charger_watchdog`

## Requirements
- R1: While charging is enabled, the WR_TICKS-th tick with no qualifying write since the last one drops chg_en in the next clock cycle and sets cause to 2'b01 (write watchdog).
- R2: While charging is enabled, the (SCL_LOW_TICKS+1)-th tick seen with scl_in continuously low drops chg_en in the next clock cycle and sets cause to 2'b10 (clock held low).
- R3: Any clock cycle in which scl_in is sampled high clears the low-time count, so a break of a single cycle restarts the low-time window.
- R4: Once disabled, chg_en stays low and cause keeps its value through any number of ticks and any scl_in activity, until a qualifying write arrives.
- R5: A pulse on wr_volt_done or wr_curr_done sets chg_en high and cause to 2'b00 in the next cycle, and restarts the write timer from zero.
- R6: After reset, chg_en is low and cause is 2'b00. Charging stays off until the first qualifying write.
- R7: A qualifying write in the same cycle as an expiring tick wins: charging remains enabled and the write timer restarts.
- R8: If both timers expire on the same tick, cause records 2'b01 (write watchdog has priority).
- R9: cause is never 2'b11 and is nonzero only while chg_en is low.
- R10: Timers advance only in cycles where tick_en is high. Clock cycles without a tick leave both counts unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One-cycle pulse per timebase tick |
| scl_in | input | 1 | Sampled level of the bus clock line |
| wr_volt_done | input | 1 | Strobe: charge-voltage register write completed |
| wr_curr_done | input | 1 | Strobe: charge-current register write completed |
| chg_en | output | 1 | Charging permitted |
| cause | output | 2 | Sticky timeout source: 00 none, 01 write watchdog, 10 clock held low |

## Verification
The write timer is run to exactly one tick short of its limit and then to the limit. This is done after writes to each of the two registers, after a restart partway through the window, and with long gaps of idle clocks between ticks, so an off-by-one in the count or counting on idle cycles shows up. The low-clock detector is tried with one unbroken low stretch and with a low stretch that has a one-cycle high break, which separates a true continuous-low measurement from a cumulative one. Two collision patterns are also run. In the first, a write lands on the expiring tick. In the second, both timers run out on the same tick. These pin down the priority rules. Stimulus applied while the block is disabled checks that nothing except a qualifying write re-enables it.

// File: rtl/cwd_pkg.sv
package cwd_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'b00,
    CAUSE_WRITE = 2'b01,
    CAUSE_SCL   = 2'b10
  } cwd_cause_e;
endpackage

// File: rtl/cwd_tick_timer.sv
module cwd_tick_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic tick,
  output logic expire
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  assign expire = run && tick && !clr && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (run && tick) begin
      cnt <= expire ? '0 : cnt + 1'b1;
    end
  end

  // Count stays inside the window; the limit is reached only via expire.
  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(LIMIT));

  // Without a tick the count holds (R10).
  assert_hold_no_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(cnt));
endmodule

// File: rtl/cwd_status.sv
module cwd_status
  import cwd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_any,
  input  logic       wr_expire,
  input  logic       scl_expire,
  output logic       en,
  output cwd_cause_e cause
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en    <= 1'b0;
      cause <= CAUSE_NONE;
    end else if (wr_any) begin
      en    <= 1'b1;
      cause <= CAUSE_NONE;
    end else if (en && wr_expire) begin
      en    <= 1'b0;
      cause <= CAUSE_WRITE;
    end else if (en && scl_expire) begin
      en    <= 1'b0;
      cause <= CAUSE_SCL;
    end
  end

  assert_write_enables_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_any |=> (en && cause == CAUSE_NONE));

  assert_wr_timeout_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wr_expire && !wr_any) |=> (!en && cause == CAUSE_WRITE));

  assert_scl_timeout_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && scl_expire && !wr_expire && !wr_any) |=> (!en && cause == CAUSE_SCL));

  assert_stay_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !wr_any) |=> (!en && $stable(cause)));

  assert_cause_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cause != 2'b11) && (en -> cause == CAUSE_NONE));
endmodule

// File: rtl/charger_watchdog.sv
module charger_watchdog
  import cwd_pkg::*;
#(
  parameter int WR_TICKS      = 175000,
  parameter int SCL_LOW_TICKS = 25
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       scl_in,
  input  logic       wr_volt_done,
  input  logic       wr_curr_done,
  output logic       chg_en,
  output logic [1:0] cause
);
  // Low time must exceed SCL_LOW_TICKS, so the detector fires one tick later.
  localparam int SCL_FIRE = SCL_LOW_TICKS + 1;

  logic       wr_any;
  logic       wr_expire;
  logic       scl_expire;
  cwd_cause_e cause_q;

  assign wr_any = wr_volt_done | wr_curr_done;

  cwd_tick_timer #(.LIMIT(WR_TICKS)) u_wr_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (wr_any),
    .run    (chg_en),
    .tick   (tick_en),
    .expire (wr_expire)
  );

  cwd_tick_timer #(.LIMIT(SCL_FIRE)) u_scl_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (scl_in),
    .run    (!scl_in),
    .tick   (tick_en),
    .expire (scl_expire)
  );

  cwd_status u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_any     (wr_any),
    .wr_expire  (wr_expire),
    .scl_expire (scl_expire),
    .en         (chg_en),
    .cause      (cause_q)
  );

  assign cause = cause_q;

  // A write on an expiring tick keeps charging on (R7).
  assert_write_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && (wr_expire || scl_expire || tick_en)) |=> chg_en);

  // Simultaneous expiry records the write watchdog (R8).
  assert_both_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_en && !wr_any && wr_expire && scl_expire) |=> (cause == 2'b01));
endmodule

// File: tb/charger_watchdog_tb.sv
module charger_watchdog_tb;
  localparam int WR  = 40;
  localparam int SCL = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0;
  logic scl_in = 1'b1;
  logic wr_volt_done = 1'b0;
  logic wr_curr_done = 1'b0;
  logic chg_en;
  logic [1:0] cause;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  charger_watchdog #(.WR_TICKS(WR), .SCL_LOW_TICKS(SCL)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .scl_in(scl_in),
    .wr_volt_done(wr_volt_done), .wr_curr_done(wr_curr_done),
    .chg_en(chg_en), .cause(cause)
  );

  task automatic check(input string req, input logic en_exp, input logic [1:0] c_exp);
    n_chk++;
    if (chg_en !== en_exp || cause !== c_exp) begin
      n_bad++;
      $display("FAIL %s: got en=%0b cause=%0d, expected en=%0b cause=%0d",
               req, chg_en, cause, en_exp, c_exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_en = 1'b1;
      @(negedge clk) tick_en = 1'b0;
      @(negedge clk);
      @(negedge clk);
    end
  endtask

  task automatic write_reg(input bit volt);
    @(negedge clk);
    wr_volt_done = volt;
    wr_curr_done = !volt;
    @(negedge clk);
    wr_volt_done = 1'b0;
    wr_curr_done = 1'b0;
  endtask

  task automatic t_reset();
    check("R6 reset", 1'b0, 2'b00);
  endtask

  task automatic t_idle_disabled();
    ticks(WR + 5);
    check("R6 no write no enable", 1'b0, 2'b00);
    scl_in = 1'b0;
    ticks(SCL + 3);
    scl_in = 1'b1;
    ticks(1);
    check("R4 scl low while off", 1'b0, 2'b00);
  endtask

  task automatic t_write_watchdog();
    write_reg(1'b1);
    check("R5 voltage write enables", 1'b1, 2'b00);
    ticks(WR - 1);
    check("R1 one tick short", 1'b1, 2'b00);
    ticks(1);
    check("R1 write watchdog fires", 1'b0, 2'b01);
    ticks(5);
    check("R4 stays off", 1'b0, 2'b01);
  endtask

  task automatic t_restart();
    write_reg(1'b0);
    check("R5 current write enables", 1'b1, 2'b00);
    ticks(30);
    write_reg(1'b1);
    ticks(WR - 1);
    check("R5 timer restarted", 1'b1, 2'b00);
    ticks(1);
    check("R1 fires after restart", 1'b0, 2'b01);
  endtask

  task automatic t_scl_low();
    write_reg(1'b0);
    scl_in = 1'b0;
    ticks(SCL);
    check("R2 low exactly limit", 1'b1, 2'b00);
    ticks(1);
    check("R2 low past limit", 1'b0, 2'b10);
    scl_in = 1'b1;
    ticks(WR + 2);
    check("R9 cause sticky", 1'b0, 2'b10);
    check("R4 scl high no reenable", 1'b0, 2'b10);
  endtask

  task automatic t_scl_break();
    write_reg(1'b1);
    scl_in = 1'b0;
    ticks(SCL - 2);
    @(negedge clk) scl_in = 1'b1;
    @(negedge clk) scl_in = 1'b0;
    ticks(SCL);
    check("R3 break restarts window", 1'b1, 2'b00);
    ticks(1);
    check("R3 fires after break", 1'b0, 2'b10);
    scl_in = 1'b1;
  endtask

  task automatic t_gaps();
    write_reg(1'b1);
    for (int i = 0; i < WR - 1; i++) begin
      ticks(1);
      repeat (7) @(negedge clk);
    end
    check("R10 idle clocks not counted", 1'b1, 2'b00);
    ticks(1);
    check("R10 fires on tick count", 1'b0, 2'b01);
  endtask

  task automatic t_write_wins();
    write_reg(1'b0);
    ticks(WR - 1);
    @(negedge clk);
    tick_en = 1'b1;
    wr_volt_done = 1'b1;
    @(negedge clk);
    tick_en = 1'b0;
    wr_volt_done = 1'b0;
    check("R7 write beats expiry", 1'b1, 2'b00);
    ticks(WR - 1);
    check("R7 timer restarted", 1'b1, 2'b00);
    ticks(1);
    check("R7 later expiry", 1'b0, 2'b01);
  endtask

  task automatic t_both();
    write_reg(1'b1);
    ticks(WR - SCL - 1);
    scl_in = 1'b0;
    ticks(SCL);
    check("R8 before joint expiry", 1'b1, 2'b00);
    ticks(1);
    check("R8 write watchdog priority", 1'b0, 2'b01);
    scl_in = 1'b1;
    ticks(1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_disabled();
    t_write_watchdog();
    t_restart();
    t_scl_low();
    t_scl_break();
    t_gaps();
    t_write_wins();
    t_both();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule